// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block forms the status byte and the ready/busy flag that a NOR-style flash shows the host while an internal program or erase algorithm is running. A command decoder elsewhere tells it when an operation starts and what kind it is. Timing logic elsewhere reports completion, time-limit failure and whether the sector-erase acceptance window is still open. The block then answers each host read with either a status word or the array data that the read would normally return.

Two toggle flip-flops form the core. Bit 6 flips on every read while an operation is active. Bit 2 flips only on reads that hit a sector being erased. Bit 7 carries the data-polling value, bit 5 flags a time-limit failure and bit 3 shows the erase window. A small state machine tracks idle, running, erase-suspended, failed and protected-target states. In the protected-target state the block shows a short busy period and then returns to idle.

Top module: `fsh_stat_gen`

## Requirements
- R1: After synchronous reset, `ready` is 1 and `rd_data` is 0x00.
- R2: When idle, a read returns `array_data` as sampled on the read strobe's rising edge.
- R3: A program (`op_kind`=0) starting from idle drops `ready` one cycle later. Reads then return bit 7 as the complement of `op_bit7`, and bits 5, 4, 3, 1 and 0 as 0.
- R4: During a sector erase (`op_kind`=1) or a chip erase (`op_kind`=2), reads return 0 in bit 7.
- R5: Bit 6 inverts on each read while an operation runs, has failed or is aimed at a protected sector. The first read after a start from idle returns bit 6 = 1, because the flip-flop is held at 0 while idle.
- R6: Bit 2 inverts on a read when a sector erase is running and `erase_map[rd_sector]` is 1, or on every read during a chip erase. In all other cases it holds its value, and it stays 0 during a program.
- R7: Bit 3 reads 0 during a sector erase while `win_open` is 1, and 1 once `win_open` is 0. It always reads 1 during a chip erase and 0 during a program.
- R8: `fail` while busy sets bit 5 and raises `ready` one cycle later. Bits 6 and 2 keep toggling. `op_done` is ignored in this state, and only `reset_cmd` returns the block to idle.
- R9: `susp` during a sector erase raises `ready`. A read of an erasing sector then returns bit 7 = 1, bit 6 held and bit 2 toggling, and a read of any other sector returns array data. Dropping `susp` makes the block busy again. `susp` has no effect during a chip erase.
- R10: A start with `op_prot`=1 keeps `ready` low for PROT_PROG_CYC cycles for a program, or PROT_ERASE_CYC cycles for an erase, and then returns to idle.
- R11: `rd_data` changes only on a rising edge of `rd_strobe`.
- R12: `op_done` during a running operation returns the block to idle, and `ready` rises one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_start | input | 1 | Start pulse for an embedded operation (accepted when idle) |
| op_kind | input | 2 | 0 program, 1 sector erase, 2 chip erase |
| op_bit7 | input | 1 | Bit 7 of the data being programmed |
| op_prot | input | 1 | The operation targets protected sectors only |
| op_done | input | 1 | Completion pulse from the algorithm |
| fail | input | 1 | Time limit exceeded |
| win_open | input | 1 | Sector-erase acceptance window still open |
| susp | input | 1 | Erase-suspend level |
| reset_cmd | input | 1 | Reset command, leaves the failed state |
| erase_map | input | NSEC | Sectors selected for erase |
| rd_strobe | input | 1 | Read strobe, one read per rising edge |
| rd_sector | input | SW | Sector index of the read address |
| array_data | input | 8 | Array contents at the read address |
| rd_data | output | 8 | Registered read result |
| ready | output | 1 | Ready (1) / busy (0) |

## Verification
The assertions check on every cycle that an accepted start makes the block busy, that a failure always releases `ready`, that `ready` never falls without a start or the end of a suspend, and that `rd_data` holds between read strobes. The bench scenarios cover the rest. They check the exact status bytes as bit 6 and bit 2 alternate across successive reads, the sector selectivity of bit 2, the window dependence of bit 3, the frozen bit 6 under suspend, and the length of the busy period for a protected target.

// File: rtl/fsh_stat_pkg.sv
package fsh_stat_pkg;
  typedef enum logic [1:0] {
    OP_PROG   = 2'd0,
    OP_SERASE = 2'd1,
    OP_CERASE = 2'd2,
    OP_RSVD   = 2'd3
  } op_kind_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RUN  = 3'd1,
    ST_SUSP = 3'd2,
    ST_FAIL = 3'd3,
    ST_PROT = 3'd4
  } st_t;

  localparam int unsigned STAT_W = 8;
  localparam int unsigned B_POLL = 7;
  localparam int unsigned B_TGL  = 6;
  localparam int unsigned B_TLIM = 5;
  localparam int unsigned B_WIN  = 3;
  localparam int unsigned B_ETGL = 2;
endpackage

// File: rtl/fsh_stat_ctl.sv
module fsh_stat_ctl
  import fsh_stat_pkg::*;
#(
  parameter int unsigned PROT_PROG_CYC  = 6,
  parameter int unsigned PROT_ERASE_CYC = 20
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     op_start,
  input  op_kind_t kind_in,
  input  logic     bit7_in,
  input  logic     prot_in,
  input  logic     op_done,
  input  logic     fail,
  input  logic     susp,
  input  logic     reset_cmd,
  output st_t      st_q,
  output op_kind_t kind_q,
  output logic     bit7_q,
  output logic     ready_q
);
  localparam int unsigned MAXC = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
  localparam int unsigned CW   = (MAXC > 1) ? $clog2(MAXC + 1) : 1;

  st_t           st_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    unique case (st_q)
      ST_IDLE: begin
        if (op_start) begin
          if (prot_in) begin
            st_n  = ST_PROT;
            cnt_n = (kind_in == OP_PROG) ? CW'(PROT_PROG_CYC - 1) : CW'(PROT_ERASE_CYC - 1);
          end else begin
            st_n = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        if (fail)                              st_n = ST_FAIL;
        else if (op_done)                      st_n = ST_IDLE;
        else if (susp && kind_q == OP_SERASE)  st_n = ST_SUSP;
      end
      ST_SUSP: begin
        if (!susp) st_n = ST_RUN;
      end
      ST_FAIL: begin
        if (reset_cmd) st_n = ST_IDLE;
      end
      ST_PROT: begin
        if (fail)              st_n = ST_FAIL;
        else if (cnt_q == '0)  st_n = ST_IDLE;
        else                   cnt_n = cnt_q - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      kind_q  <= OP_PROG;
      bit7_q  <= 1'b0;
      ready_q <= 1'b1;
    end else begin
      st_q    <= st_n;
      cnt_q   <= cnt_n;
      ready_q <= !(st_n == ST_RUN || st_n == ST_PROT);
      if (st_q == ST_IDLE && op_start) begin
        kind_q <= kind_in;
        bit7_q <= bit7_in;
      end
    end
  end
endmodule

// File: rtl/fsh_stat_tgl.sv
module fsh_stat_tgl (
  input  logic clk,
  input  logic rst,
  input  logic rd_strobe,
  input  logic clr,
  input  logic en6,
  input  logic en2,
  output logic rd_rise,
  output logic t6_n,
  output logic t2_n
);
  logic prev_q, t6_q, t2_q;

  always_comb begin
    rd_rise = rd_strobe & ~prev_q;
    if (clr) begin
      t6_n = 1'b0;
      t2_n = 1'b0;
    end else begin
      t6_n = (rd_rise && en6) ? ~t6_q : t6_q;
      t2_n = (rd_rise && en2) ? ~t2_q : t2_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      t6_q   <= 1'b0;
      t2_q   <= 1'b0;
    end else begin
      prev_q <= rd_strobe;
      t6_q   <= t6_n;
      t2_q   <= t2_n;
    end
  end
endmodule

// File: rtl/fsh_stat_fmt.sv
module fsh_stat_fmt
  import fsh_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_rise,
  input  logic              show_status,
  input  logic              dq7,
  input  logic              dq5,
  input  logic              dq3,
  input  logic              t6,
  input  logic              t2,
  input  logic [STAT_W-1:0] array_data,
  output logic [STAT_W-1:0] rd_data
);
  logic [STAT_W-1:0] word;

  always_comb begin
    word = '0;
    if (show_status) begin
      word[B_POLL] = dq7;
      word[B_TGL]  = t6;
      word[B_TLIM] = dq5;
      word[B_WIN]  = dq3;
      word[B_ETGL] = t2;
    end else begin
      word = array_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_data <= '0;
    else if (rd_rise) rd_data <= word;
  end
endmodule

// File: rtl/fsh_stat_gen.sv
module fsh_stat_gen
  import fsh_stat_pkg::*;
#(
  parameter int unsigned NSEC           = 19,
  parameter int unsigned SW             = (NSEC > 1) ? $clog2(NSEC) : 1,
  parameter int unsigned PROT_PROG_CYC  = 6,
  parameter int unsigned PROT_ERASE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_start,
  input  logic [1:0]        op_kind,
  input  logic              op_bit7,
  input  logic              op_prot,
  input  logic              op_done,
  input  logic              fail,
  input  logic              win_open,
  input  logic              susp,
  input  logic              reset_cmd,
  input  logic [NSEC-1:0]   erase_map,
  input  logic              rd_strobe,
  input  logic [SW-1:0]     rd_sector,
  input  logic [STAT_W-1:0] array_data,
  output logic [STAT_W-1:0] rd_data,
  output logic              ready
);
  st_t      st;
  op_kind_t kind;
  logic     bit7;
  logic     rd_rise, t6_n, t2_n;
  logic     sec_hit, in_erase, is_erase;
  logic     active, en6, en2, show, dq7, dq5, dq3;

  fsh_stat_ctl #(
    .PROT_PROG_CYC (PROT_PROG_CYC),
    .PROT_ERASE_CYC(PROT_ERASE_CYC)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .op_start (op_start),
    .kind_in  (op_kind_t'(op_kind)),
    .bit7_in  (op_bit7),
    .prot_in  (op_prot),
    .op_done  (op_done),
    .fail     (fail),
    .susp     (susp),
    .reset_cmd(reset_cmd),
    .st_q     (st),
    .kind_q   (kind),
    .bit7_q   (bit7),
    .ready_q  (ready)
  );

  always_comb begin
    sec_hit = 1'b0;
    for (int i = 0; i < NSEC; i++) begin
      if (rd_sector == SW'(i)) sec_hit = sec_hit | erase_map[i];
    end
  end

  always_comb begin
    is_erase = (kind == OP_SERASE) || (kind == OP_CERASE);
    in_erase = (kind == OP_CERASE) || (kind == OP_SERASE && sec_hit);
    active   = (st == ST_RUN) || (st == ST_FAIL) || (st == ST_PROT);
    en6      = active;
    en2      = ((st == ST_RUN) || (st == ST_FAIL) || (st == ST_SUSP)) && in_erase;
    show     = active || (st == ST_SUSP && in_erase);
    dq5      = (st == ST_FAIL);
    if (st == ST_SUSP) begin
      dq7 = 1'b1;
      dq3 = 1'b0;
    end else begin
      dq7 = (kind == OP_PROG) ? ~bit7 : 1'b0;
      dq3 = is_erase && !(kind == OP_SERASE && win_open && st == ST_RUN);
    end
  end

  fsh_stat_tgl u_tgl (
    .clk      (clk),
    .rst      (rst),
    .rd_strobe(rd_strobe),
    .clr      (st == ST_IDLE),
    .en6      (en6),
    .en2      (en2),
    .rd_rise  (rd_rise),
    .t6_n     (t6_n),
    .t2_n     (t2_n)
  );

  fsh_stat_fmt u_fmt (
    .clk        (clk),
    .rst        (rst),
    .rd_rise    (rd_rise),
    .show_status(show),
    .dq7        (dq7),
    .dq5        (dq5),
    .dq3        (dq3),
    .t6         (t6_n),
    .t2         (t2_n),
    .array_data (array_data),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/fsh_stat_chk.sv
module fsh_stat_chk (
  input logic       clk,
  input logic       rst,
  input logic       op_start,
  input logic       op_prot,
  input logic       fail,
  input logic       susp,
  input logic       rd_strobe,
  input logic [7:0] rd_data,
  input logic       ready
);
  // R3 / R10: an accepted start always makes the block busy
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (ready && op_start && !$past(ready == 1'b0) && !susp) |=> !ready);

  // R8: a failure while busy always hands back ready
  p_fail_ready_r8: assert property (@(posedge clk) disable iff (rst)
    (!ready && fail) |=> ready);

  // R9 / R12: ready only falls through a start or the end of a suspend
  p_ready_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (ready && !op_start && !$fell(susp)) |=> ready);

  // R11: read data holds between strobe rising edges
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe && !$past(rd_strobe)) |=> $stable(rd_data));

  // R10: a protected start is busy on the next cycle as well
  p_prot_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (ready && op_start && op_prot && !susp && !$past(ready == 1'b0)) |=> !ready);
endmodule

bind fsh_stat_gen fsh_stat_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_start (op_start),
  .op_prot  (op_prot),
  .fail     (fail),
  .susp     (susp),
  .rd_strobe(rd_strobe),
  .rd_data  (rd_data),
  .ready    (ready)
);

// File: tb/fsh_stat_gen_tb.sv
module fsh_stat_gen_tb_top;
  localparam int NSEC = 19;
  localparam int SW   = 5;
  localparam int PPC  = 6;
  localparam int PEC  = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            op_start = 0, op_bit7 = 0, op_prot = 0, op_done = 0;
  logic [1:0]      op_kind = 0;
  logic            fail = 0, win_open = 0, susp = 0, reset_cmd = 0, rd_strobe = 0;
  logic [NSEC-1:0] erase_map = '0;
  logic [SW-1:0]   rd_sector = '0;
  logic [7:0]      array_data = '0;
  logic [7:0]      rd_data;
  logic            ready;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  fsh_stat_gen #(.NSEC(NSEC), .SW(SW), .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC)) dut_i (
    .clk(clk), .rst(rst), .op_start(op_start), .op_kind(op_kind), .op_bit7(op_bit7),
    .op_prot(op_prot), .op_done(op_done), .fail(fail), .win_open(win_open), .susp(susp),
    .reset_cmd(reset_cmd), .erase_map(erase_map), .rd_strobe(rd_strobe), .rd_sector(rd_sector),
    .array_data(array_data), .rd_data(rd_data), .ready(ready));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // driver: one read, expected value pushed for the monitor
  task automatic rd(input int sec, input logic [7:0] arr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_sector  = SW'(sec);
    array_data = arr;
    rd_strobe  = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic start(input logic [1:0] k, input logic b7, input logic prot);
    @(negedge clk);
    op_start = 1; op_kind = k; op_bit7 = b7; op_prot = prot;
    @(negedge clk);
    op_start = 0; op_prot = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); op_done = 1;
    @(negedge clk); op_done = 0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (rd_strobe) begin
        @(negedge clk);
        if (exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", {7'd0, ready}, 8'h01);
    chk("R1 rd_data", rd_data, 8'h00);
    rst = 0;
    // R2 idle read
    rd(3, 8'hA5, 8'hA5, "R2 idle array");
    // R11 no strobe -> unchanged
    @(negedge clk); array_data = 8'h5A;
    repeat (2) @(negedge clk);
    chk("R11 hold", rd_data, 8'hA5);

    // R3 program bit7=1
    start(2'd0, 1'b1, 1'b0);
    chk("R3 busy", {7'd0, ready}, 8'h00);
    rd(0, 8'hFF, 8'h40, "R3 R5 R6 R7 prog read1");
    rd(0, 8'hFF, 8'h00, "R5 prog read2");
    rd(0, 8'hFF, 8'h40, "R5 prog read3");
    pulse_done();
    chk("R12 ready", {7'd0, ready}, 8'h01);
    rd(0, 8'h3C, 8'h3C, "R12 array after done");
    // program bit7=0
    start(2'd0, 1'b0, 1'b0);
    rd(1, 8'h00, 8'hC0, "R3 prog complement");
    pulse_done();

    // sector erase on sector 4
    erase_map = '0; erase_map[4] = 1'b1; win_open = 1;
    start(2'd1, 1'b0, 1'b0);
    rd(4, 8'hFF, 8'h44, "R4 R6 R7 serase window open");
    @(negedge clk); win_open = 0;
    rd(4, 8'hFF, 8'h08, "R7 serase window closed");
    rd(5, 8'hFF, 8'h48, "R6 non-erasing sector no dq2");
    // suspend
    @(negedge clk); susp = 1;
    @(negedge clk);
    chk("R9 suspend ready", {7'd0, ready}, 8'h01);
    rd(4, 8'hFF, 8'hC4, "R9 suspended sector read1");
    rd(4, 8'hFF, 8'hC0, "R9 suspended sector read2");
    rd(5, 8'h11, 8'h11, "R9 other sector array");
    @(negedge clk); susp = 0;
    @(negedge clk);
    chk("R9 resume busy", {7'd0, ready}, 8'h00);
    rd(4, 8'hFF, 8'h0C, "R5 R9 after resume");
    // failure
    @(negedge clk); fail = 1;
    @(negedge clk); fail = 0;
    chk("R8 fail ready", {7'd0, ready}, 8'h01);
    rd(4, 8'hFF, 8'h68, "R8 fail read1");
    pulse_done();
    rd(4, 8'hFF, 8'h2C, "R8 done ignored read2");
    @(negedge clk); reset_cmd = 1;
    @(negedge clk); reset_cmd = 0;
    rd(4, 8'h77, 8'h77, "R8 reset_cmd to idle");

    // chip erase
    erase_map = '0;
    start(2'd2, 1'b0, 1'b0);
    rd(9, 8'hFF, 8'h4C, "R4 R6 R7 cerase read1");
    rd(0, 8'hFF, 8'h08, "R6 cerase read2");
    @(negedge clk); susp = 1;
    @(negedge clk);
    chk("R9 no suspend in chip erase", {7'd0, ready}, 8'h00);
    susp = 0;
    pulse_done();
    chk("R12 cerase done", {7'd0, ready}, 8'h01);

    // protected program
    start(2'd0, 1'b1, 1'b1);
    repeat (PPC - 1) @(negedge clk);
    chk("R10 prot prog still busy", {7'd0, ready}, 8'h00);
    @(negedge clk);
    chk("R10 prot prog released", {7'd0, ready}, 8'h01);
    // protected erase
    start(2'd1, 1'b0, 1'b1);
    repeat (PEC - 1) @(negedge clk);
    chk("R10 prot erase still busy", {7'd0, ready}, 8'h00);
    @(negedge clk);
    chk("R10 prot erase released", {7'd0, ready}, 8'h01);
    rd(2, 8'h99, 8'h99, "R10 idle after prot");

    // R1 reset during an operation
    start(2'd0, 1'b1, 1'b0);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset mid-op ready", {7'd0, ready}, 8'h01);
    chk("R1 reset mid-op data", rd_data, 8'h00);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule